// File: doc/BRIEF.md
# Programmable Counter-Timer Baud Clock

This block divides the input clock by a programmable 16-bit preset to make a 16x baud clock for the serial channels around it. Software writes the preset as two bytes, selects timer mode in an auxiliary-control byte, and then starts the counter by reading a dedicated start address. The read strobe is the command and carries no data. From then on the counter runs down from the preset and reloads itself. Each time it expires, it flips a square-wave output, so one full output period lasts twice the preset in input clocks. To get a given baud rate, software loads the preset as the input clock divided by 32 times the baud rate, rounded to the nearest integer.

Each channel has its own clock-select byte with two 4-bit codes, one for the receiver and one for the transmitter. When a code equals the timer-mode value, that direction receives a one-cycle enable on every rising edge of the square wave, and uses it as its 16x sampling tick. Other codes are passed out unchanged, together with the baud-set bit from the auxiliary byte, so that a neighbouring fixed-rate generator can decode them.

Top module: `bgen_ctimer`

## Requirements
- R1: After reset the square wave, the tick and all channel enables are low, and they stay low until a start command is given.
- R2: A write to address 6 loads the preset's upper byte and a write to address 7 loads its lower byte. A read of address 14 (the start command) loads the counter from the preset and drives the wave low on the next cycle.
- R3: While running in timer mode, the wave changes level every P input clocks, where P is the effective preset. A full period is therefore 2×P clocks, and the first rise comes P clocks after the start edge.
- R4: The tick output is high for exactly one cycle, the cycle in which the wave has just risen.
- R5: A preset written while the counter runs does not disturb the level in progress. It applies from the next reload onward.
- R6: A start command given while the counter runs restarts it at once: the wave goes low and the next rise follows P clocks later, using the current preset.
- R7: Preset values 0 and 1 behave as 2, so the shortest full period is 4 clocks.
- R8: The counter advances only while bits 6:4 of the auxiliary byte (written at address 4) equal 6. With any other value the wave holds its level and no tick is produced.
- R9: Channel c's clock-select byte is written at address 8·c+1. Its upper nibble is the receive code and its lower nibble is the transmit code, and both are presented on `rx_sel`/`tx_sel` at nibble c. The receive or transmit enable of channel c equals the tick whenever its code is 0xD, and is low otherwise.
- R10: The `baud_set` output follows bit 7 of the last byte written at address 4.
- R11: A write to address 14 and a read of any other address do not start the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the divider source |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (only the start address has an effect) |
| addr | input | ADDR_W (4) | Register address |
| wdata | input | DATA_W (8) | Write data |
| timer_wave | output | 1 | Square-wave output of the counter |
| tick16 | output | 1 | One-cycle pulse on each rising edge of the wave |
| rx_en | output | NUM_CH (2) | Per-channel receive 16x enable |
| tx_en | output | NUM_CH (2) | Per-channel transmit 16x enable |
| rx_sel | output | 4·NUM_CH (8) | Receive select codes, nibble c for channel c |
| tx_sel | output | 4·NUM_CH (8) | Transmit select codes, nibble c for channel c |
| baud_set | output | 1 | Baud-set choice from the auxiliary byte |

## Verification
The bench builds the block with its defaults: two channels and 8-bit data, which gives a 16-bit preset. With two channels, the second clock-select byte sits at address 9, so the channel stride and the per-nibble routing are both exercised. One channel routes only its receiver to the timer, which shows that the two directions are decoded independently. Short presets let many complete periods, restarts and mid-run preset changes fit into a short run. A preset of 259 sets a bit in the upper byte, and presets 0 and 1 reach the clamp at the lower bound.

// File: rtl/bgen_pkg.sv
// Package: shared register offsets, mode codes and the auxiliary byte type
// for the counter-timer baud clock. Assumes 8-bit data and a channel stride
// of eight addresses.
package bgen_pkg;

    // Global register offsets (absolute addresses)
    localparam int unsigned OFS_AUX       = 4;
    localparam int unsigned OFS_PRESET_HI = 6;
    localparam int unsigned OFS_PRESET_LO = 7;
    localparam int unsigned OFS_START     = 14;

    // Per-channel clock-select offset within the channel window
    localparam int unsigned OFS_CLKSEL    = 1;
    localparam int unsigned CH_STRIDE     = 8;

    // Code in a clock-select nibble that routes the timer to that direction
    localparam logic [3:0]  SEL_TIMER     = 4'hD;

    // Auxiliary mode field value: timer driven by the input clock
    localparam logic [2:0]  AUX_MODE_TIMER = 3'd6;

    // Smallest preset the counter honours
    localparam int unsigned MIN_PRESET    = 2;

    // Upper half of the auxiliary byte that the block keeps
    typedef struct packed {
        logic       baud_set;
        logic [2:0] mode;
    } aux_t;

endpackage

// File: rtl/bgen_regs.sv
// Module: register file of the counter-timer baud clock.
// Holds the preset (two byte lanes), the upper half of the auxiliary byte
// and one clock-select byte per channel. Assumes the preset is exactly twice
// the data width and that addresses decode without wait states.
module bgen_regs
    import bgen_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [CNT_W-1:0]      preset,
    output aux_t                  aux,
    output logic [NUM_CH*4-1:0]   rx_sel,
    output logic [NUM_CH*4-1:0]   tx_sel
);

    localparam logic [ADDR_W-1:0] A_AUX = ADDR_W'(OFS_AUX);
    localparam logic [ADDR_W-1:0] A_PHI = ADDR_W'(OFS_PRESET_HI);
    localparam logic [ADDR_W-1:0] A_PLO = ADDR_W'(OFS_PRESET_LO);

    logic wr_aux;
    logic wr_phi;
    logic wr_plo;

    // Decode the global write targets
    always_comb begin
        wr_aux = wr_en && (addr == A_AUX);
        wr_phi = wr_en && (addr == A_PHI);
        wr_plo = wr_en && (addr == A_PLO);
    end

    // Preset byte lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preset <= '0;
        end else begin
            if (wr_phi) begin
                preset[CNT_W-1:DATA_W] <= wdata;
            end
            if (wr_plo) begin
                preset[DATA_W-1:0] <= wdata;
            end
        end
    end

    // Baud-set bit and mode field of the auxiliary byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux <= '0;
        end else if (wr_aux) begin
            aux <= aux_t'(wdata[DATA_W-1:DATA_W-4]);
        end
    end

    // One clock-select register per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_clksel
        localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(c * CH_STRIDE + OFS_CLKSEL);

        logic [3:0] rx_q;
        logic [3:0] tx_q;

        // Capture both codes of this channel's select byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rx_q <= '0;
                tx_q <= '0;
            end else if (wr_en && (addr == A_SEL)) begin
                rx_q <= wdata[7:4];
                tx_q <= wdata[3:0];
            end
        end

        assign rx_sel[c*4 +: 4] = rx_q;
        assign tx_sel[c*4 +: 4] = tx_q;
    end

endmodule

// File: rtl/bgen_timer.sv
// Module: reloading down-counter with a toggling output.
// Loads the effective preset on start, counts down while enabled, and on
// reaching one reloads and flips the wave, giving a period of twice the
// preset. Assumes start has priority over counting.
module bgen_timer
    import bgen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             enable,
    input  logic [CNT_W-1:0] preset,
    output logic             wave,
    output logic             tick,
    output logic             running
);

    localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PRESET);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    // Clamp presets below the minimum
    always_comb begin
        load_val = (preset < MIN_P) ? MIN_P : preset;
    end

    // Terminal count reached this cycle
    always_comb begin
        expire = running && enable && (cnt_q <= ONE);
    end

    // Counter, run flag, wave and rising-edge tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            running <= 1'b0;
            wave    <= 1'b0;
            tick    <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (start) begin
                cnt_q   <= load_val;
                running <= 1'b1;
                wave    <= 1'b0;
            end else if (expire) begin
                cnt_q <= load_val;
                wave  <= ~wave;
                tick  <= ~wave;
            end else if (running && enable) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

endmodule

// File: rtl/bgen_route.sv
// Module: per-channel routing of the timer tick.
// Each direction of each channel receives the tick only when its select code
// names timer mode. Purely combinational.
module bgen_route
    import bgen_pkg::*;
#(
    parameter int unsigned NUM_CH = 2
) (
    input  logic                tick,
    input  logic                timer_ok,
    input  logic [NUM_CH*4-1:0] rx_sel,
    input  logic [NUM_CH*4-1:0] tx_sel,
    output logic [NUM_CH-1:0]   rx_en,
    output logic [NUM_CH-1:0]   tx_en
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Gate the tick into this channel's receive and transmit enables
        always_comb begin
            rx_en[c] = tick && timer_ok && (rx_sel[c*4 +: 4] == SEL_TIMER);
            tx_en[c] = tick && timer_ok && (tx_sel[c*4 +: 4] == SEL_TIMER);
        end
    end

endmodule

// File: rtl/bgen_ctimer.sv
// Module: counter-timer baud clock, top level.
// Decodes the start-read strobe, holds the registers, runs the divider and
// routes its tick to the channels. Assumes single-cycle strobes from a
// synchronous bus in the same clock domain.
module bgen_ctimer
    import bgen_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic                timer_wave,
    output logic                tick16,
    output logic [NUM_CH-1:0]   rx_en,
    output logic [NUM_CH-1:0]   tx_en,
    output logic [NUM_CH*4-1:0] rx_sel,
    output logic [NUM_CH*4-1:0] tx_sel,
    output logic                baud_set
);

    localparam int unsigned CNT_W = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);

    logic [CNT_W-1:0] preset;
    aux_t             aux;
    logic             start_cmd;
    logic             aux_timer_mode;
    logic             timer_run;

    // Start command: a read of the start address
    always_comb begin
        start_cmd = rd_en && (addr == A_START);
    end

    // Timer mode selected in the auxiliary byte
    always_comb begin
        aux_timer_mode = (aux.mode == AUX_MODE_TIMER);
    end

    assign baud_set = aux.baud_set;

    bgen_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .preset (preset),
        .aux    (aux),
        .rx_sel (rx_sel),
        .tx_sel (tx_sel)
    );

    bgen_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_cmd),
        .enable  (aux_timer_mode),
        .preset  (preset),
        .wave    (timer_wave),
        .tick    (tick16),
        .running (timer_run)
    );

    bgen_route #(
        .NUM_CH (NUM_CH)
    ) u_route (
        .tick     (tick16),
        .timer_ok (timer_run),
        .rx_sel   (rx_sel),
        .tx_sel   (tx_sel),
        .rx_en    (rx_en),
        .tx_en    (tx_en)
    );

endmodule

// File: rtl/bgen_ctimer_chk.sv
// Module: assertion checker for bgen_ctimer, bound to every instance.
// Observes the bus, the outputs and the timer's run and mode state.
module bgen_ctimer_chk
    import bgen_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic                timer_wave,
    input logic                tick16,
    input logic [NUM_CH-1:0]   rx_en,
    input logic [NUM_CH-1:0]   tx_en,
    input logic                baud_set,
    input logic                aux_timer_mode,
    input logic                timer_run
);

    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
    localparam logic [ADDR_W-1:0] A_AUX   = ADDR_W'(OFS_AUX);
    localparam int unsigned       LEN_MAX = 1000;

    logic        start_seen;
    logic        start_d;
    logic        wave_d;
    int unsigned level_len;

    assign start_seen = rd_en && (addr == A_START);

    // Length of the wave level that just ended, and the start strobe delayed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_d    <= 1'b0;
            start_d   <= 1'b0;
            level_len <= 0;
        end else begin
            wave_d  <= timer_wave;
            start_d <= start_seen;
            if (timer_wave != wave_d) begin
                level_len <= 1;
            end else if (level_len < LEN_MAX) begin
                level_len <= level_len + 1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_run |-> (!timer_wave && !tick16)); // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> (!timer_wave && !tick16)); // R6

    AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |-> $rose(timer_wave)); // R4

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |=> !tick16); // R4

    AST_MIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((timer_wave != wave_d) && !start_d) |-> (level_len >= MIN_PRESET)); // R7

    AST_HOLD_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_seen && !aux_timer_mode) |=> ($stable(timer_wave) && !tick16)); // R8

    AST_BAUD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_AUX)) |=> (baud_set == $past(wdata[DATA_W-1]))); // R10

    for (genvar c = 0; c < NUM_CH; c++) begin : g_en_chk
        AST_RX_EN_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            rx_en[c] |-> tick16); // R9
        AST_TX_EN_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            tx_en[c] |-> tick16); // R9
    end

endmodule

bind bgen_ctimer bgen_ctimer_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .addr           (addr),
    .wdata          (wdata),
    .timer_wave     (timer_wave),
    .tick16         (tick16),
    .rx_en          (rx_en),
    .tx_en          (tx_en),
    .baud_set       (baud_set),
    .aux_timer_mode (aux_timer_mode),
    .timer_run      (timer_run)
);

// File: tb/bgen_ctimer_tb.sv
`timescale 1ns/1ps
module bgen_ctimer_tb;

    localparam int NUM_CH = 2;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic                rd_en = 1'b0;
    logic [ADDR_W-1:0]   addr = '0;
    logic [DATA_W-1:0]   wdata = '0;
    logic                timer_wave;
    logic                tick16;
    logic [NUM_CH-1:0]   rx_en;
    logic [NUM_CH-1:0]   tx_en;
    logic [NUM_CH*4-1:0] rx_sel;
    logic [NUM_CH*4-1:0] tx_sel;
    logic                baud_set;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    bgen_ctimer #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .timer_wave(timer_wave), .tick16(tick16), .rx_en(rx_en),
        .tx_en(tx_en), .rx_sel(rx_sel), .tx_sel(tx_sel), .baud_set(baud_set)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: registers as bytes, the divider as integers
    int       m_preset = 0;
    int       m_cnt = 0;
    bit       m_run = 0;
    bit       m_wave = 0;
    bit       m_tick = 0;
    bit [7:0] m_aux = 0;
    bit [7:0] m_sel [NUM_CH];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_preset = 0; m_cnt = 0; m_run = 0; m_wave = 0; m_tick = 0; m_aux = 0;
            for (int c = 0; c < NUM_CH; c++) m_sel[c] = 0;
        end else begin
            int p;
            p = (m_preset < 2) ? 2 : m_preset;
            m_tick = 0;
            if (rd_en && addr == 14) begin
                m_cnt = p; m_wave = 0; m_run = 1;
            end else if (m_run && m_aux[6:4] == 3'd6) begin
                if (m_cnt <= 1) begin
                    m_cnt = p; m_wave = !m_wave; m_tick = m_wave;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (wr_en) begin
                if (addr == 6) m_preset = (m_preset & 'hFF) | (int'(wdata) << 8);
                if (addr == 7) m_preset = (m_preset & 'hFF00) | int'(wdata);
                if (addr == 4) m_aux = wdata;
                for (int c = 0; c < NUM_CH; c++)
                    if (int'(addr) == c * 8 + 1) m_sel[c] = wdata;
            end
        end
    end

    // Compare every cycle against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 wave", int'(timer_wave), int'(m_wave));
            chk("R4 tick", int'(tick16), int'(m_tick));
            chk("R10 baud_set", int'(baud_set), int'(m_aux[7]));
            for (int c = 0; c < NUM_CH; c++) begin
                chk("R9 rx_en", int'(rx_en[c]), int'(m_tick && m_sel[c][7:4] == 4'hD));
                chk("R9 tx_en", int'(tx_en[c]), int'(m_tick && m_sel[c][3:0] == 4'hD));
                chk("R9 rx_sel", int'(rx_sel[c*4 +: 4]), int'(m_sel[c][7:4]));
                chk("R9 tx_sel", int'(tx_sel[c*4 +: 4]), int'(m_sel[c][3:0]));
            end
        end
    end

    task automatic bus_wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic next_rise(output int at);
        logic p;
        p = timer_wave;
        at = -1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (timer_wave && !p) begin
                at = cyc;
                break;
            end
            p = timer_wave;
        end
    endtask

    task automatic period(input string tag, input int exp);
        int a;
        int b;
        next_rise(a);
        next_rise(b);
        chk(tag, b - a, exp);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int t0;
        int t1;
        int ticks;
        int rxc;
        int txc;
        int edges;
        logic w0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset wave", int'(timer_wave), 0);
        chk("R1 reset tick", int'(tick16), 0);
        chk("R1 reset enables", int'({rx_en, tx_en}), 0);

        // Configure, then try strobes that must not start the counter
        bus_wr(4, 'h60);
        bus_wr(1, 'hDD);
        bus_wr(9, 'hD0);
        bus_wr(6, 0);
        bus_wr(7, 5);
        bus_wr(14, 'hFF);
        bus_rd(6);
        bus_rd(15);
        edges = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (timer_wave) edges++;
        end
        chk("R11 no start on other strobes", edges, 0);
        chk("R1 quiet before start", int'(tick16), 0);
        chk("R9 rx_sel field", int'(rx_sel), 'hDD);
        chk("R9 tx_sel field", int'(tx_sel), 'h0D);
        chk("R10 baud_set low", int'(baud_set), 0);
        bus_wr(4, 'hE0);
        chk("R10 baud_set high", int'(baud_set), 1);

        // Start and measure
        bus_rd(14);
        t0 = cyc;
        chk("R2 wave low after start", int'(timer_wave), 0);
        next_rise(t1);
        chk("R3 first rise delay", t1 - t0, 5);
        period("R3 period preset 5", 10);
        ticks = 0; rxc = 0; txc = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            ticks += int'(tick16);
            rxc += int'(rx_en[1]);
            txc += int'(tx_en[1]);
        end
        chk("R4 ticks in 40 cycles", ticks, 4);
        chk("R9 rx_en ch1 pulses", rxc, 4);
        chk("R9 tx_en ch1 silent", txc, 0);

        // Preset change while running
        bus_wr(7, 7);
        next_rise(t0);
        period("R5 new preset after reload", 14);

        // Restart mid-run
        repeat (3) @(negedge clk);
        bus_rd(14);
        t0 = cyc;
        chk("R6 restart wave low", int'(timer_wave), 0);
        next_rise(t1);
        chk("R6 rise after restart", t1 - t0, 7);

        // Clamp of tiny presets
        bus_wr(7, 1);
        bus_rd(14);
        period("R7 preset 1", 4);
        bus_wr(7, 0);
        bus_rd(14);
        period("R7 preset 0", 4);

        // Upper byte
        bus_wr(6, 1);
        bus_wr(7, 3);
        bus_rd(14);
        period("R2 preset 259", 518);

        // Mode field off freezes the divider
        bus_wr(6, 0);
        bus_wr(7, 5);
        bus_rd(14);
        repeat (3) @(negedge clk);
        bus_wr(4, 'h00);
        chk("R10 baud_set cleared", int'(baud_set), 0);
        w0 = timer_wave;
        edges = 0; ticks = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (timer_wave != w0) edges++;
            ticks += int'(tick16);
        end
        chk("R8 wave frozen", edges, 0);
        chk("R8 no tick when off", ticks, 0);
        bus_wr(4, 'h60);
        period("R8 resumes in timer mode", 10);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule